// File: doc/BRIEF.md
# Two-Wire Write-Only Control Slave

This block listens on a two-wire serial bus as a write-only target and holds the settings of a dual-loop radio synthesizer. It samples the clock and data lines with a fast system clock, cleans them up, and finds start and stop conditions on the cleaned lines. When the address byte matches the fixed device address, the block acknowledges that byte and every data byte that follows it until the next stop or start.

The first bit of each data byte selects where the other seven bits go. A first bit of 1 sends them to the channel register, and a first bit of 0 sends them to the test-mode register. A host can therefore write both registers in one frame, or change only one of them with a one-byte frame.

The channel code is also turned into a synthesizer index and a feedback ratio. The ratio is given in eighths, so the downstream loop logic never handles a fraction. The outputs are the two register values, the index, the ratio, a one-cycle strobe for each register, and the pull-down control for the data line.

Top module: `ctl2w_slave`

## Requirements
- R1: A frame opens only when the data line falls while the clock line is high. When the data line rises while the clock line is high, the frame closes. Bytes clocked after a stop without a fresh start are not acknowledged and change nothing.
- R2: If the first byte after a start equals 8'hC0 (MSB first), the block pulls the data line low (`sda_drive_o`=1) for the ninth clock. With any other value the line stays released for the rest of the frame, and no data byte in that frame is acknowledged or stored.
- R3: Every data byte that follows a matched address is acknowledged on its ninth clock, whatever its value.
- R4: A data byte whose bit 7 is 1 loads its bits 6..0 into `chan_code_o`.
- R5: A data byte whose bit 7 is 0 loads its bits 6..0 into `test_mode_o`.
- R6: After reset, `chan_code_o`=7'b1000101, `test_mode_o`=0, `synth_index_o`=69, `ratio_x8_o`=2949 and `sda_drive_o`=0.
- R7: Each stored byte raises the strobe for its register (`chan_upd_o` or `test_upd_o`) for exactly one clock, at the moment the acknowledge begins. The two strobes are never high together.
- R8: `synth_index_o` equals the channel code for codes 6 to 127. For codes 0 to 5 it equals the code plus 128.
- R9: `ratio_x8_o` equals 2880 plus `synth_index_o`, which is eight times the feedback ratio.
- R10: If a start arrives part way through a byte, that byte is dropped and neither register changes. The next byte is then treated as an address.
- R11: The acknowledge pull-down is released once the clock falls at the end of the ninth pulse. It is already released during the first bit of the next byte.
- R12: A pulse on the clock line that lasts a single system-clock cycle is filtered out and does not count as a bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_drive_o | output | 1 | 1 pulls the data line low (acknowledge) |
| chan_code_o | output | 7 | Channel-select register |
| test_mode_o | output | 7 | Test-mode register |
| synth_index_o | output | 8 | Decoded synthesizer index |
| ratio_x8_o | output | 12 | Feedback ratio times eight |
| chan_upd_o | output | 1 | One-cycle strobe: channel register written |
| test_upd_o | output | 1 | One-cycle strobe: test register written |

## Verification
Two functions can overlap in one frame. A register commit can overlap with a start that arrives inside a byte, and a channel commit can overlap with the index refresh that follows it one cycle later. The bench sends a start after only a few bits of a data byte. It then checks that neither strobe fired and that both registers keep their values, while the checker requires that every index change follows a channel strobe. The bench also sends back-to-back two-byte frames, where the two strobes come only one byte apart, and checks that the strobe counts match the number of stored bytes.

// File: rtl/ctl2w_pkg.sv
package ctl2w_pkg;
  localparam int CODE_W   = 7;
  localparam int IDX_W    = CODE_W + 1;
  localparam int RATIO_W  = 12;
  localparam int BYTE_W   = CODE_W + 1;
  localparam logic [BYTE_W-1:0] DEV_ADDR   = 8'hC0;
  localparam logic [CODE_W-1:0] CHAN_RESET = 7'b1000101;
  localparam int WRAP_LIMIT  = 6;
  localparam int RATIO_BASE8 = 2880;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_DATA,
    ST_DATA_ACK,
    ST_SKIP
  } frame_state_t;

  function automatic logic [IDX_W-1:0] code_to_index(input logic [CODE_W-1:0] code);
    if (int'(code) < WRAP_LIMIT) code_to_index = {1'b1, code};
    else code_to_index = {1'b0, code};
  endfunction
endpackage

// File: rtl/ctl2w_line_filter.sv
module ctl2w_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int VOTE_TAPS   = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic line_o
);
  localparam int NEED = (VOTE_TAPS / 2) + 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [VOTE_TAPS-1:0]   hist_q;
  logic [$clog2(VOTE_TAPS+1)-1:0] ones;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sync_q[g] <= 1'b1;
          else     sync_q[g] <= line_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sync_q[g] <= 1'b1;
          else     sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) hist_q <= '1;
    else     hist_q <= {hist_q[VOTE_TAPS-2:0], sync_q[SYNC_STAGES-1]};
  end

  always_comb begin
    ones = '0;
    for (int i = 0; i < VOTE_TAPS; i++) ones = ones + hist_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) line_o <= 1'b1;
    else     line_o <= (int'(ones) >= NEED);
  end
endmodule

// File: rtl/ctl2w_frame_engine.sv
module ctl2w_frame_engine
  import ctl2w_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_f,
  input  logic              sda_f,
  output logic              drive_o,
  output logic [CODE_W-1:0] chan_o,
  output logic [CODE_W-1:0] test_o,
  output logic              chan_upd_o,
  output logic              test_upd_o
);
  localparam int CNT_W = $clog2(BYTE_W + 1);

  frame_state_t      state;
  logic              scl_q, sda_q;
  logic [BYTE_W-1:0] shreg;
  logic [CNT_W-1:0]  bitcnt;
  logic scl_rise, scl_fall, start_ev, stop_ev, byte_full;

  assign scl_rise  = scl_f & ~scl_q;
  assign scl_fall  = ~scl_f & scl_q;
  assign start_ev  = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_ev   = scl_f & scl_q & ~sda_q & sda_f;
  assign byte_full = (int'(bitcnt) == BYTE_W);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      scl_q      <= 1'b1;
      sda_q      <= 1'b1;
      shreg      <= '0;
      bitcnt     <= '0;
      drive_o    <= 1'b0;
      chan_o     <= CHAN_RESET;
      test_o     <= '0;
      chan_upd_o <= 1'b0;
      test_upd_o <= 1'b0;
    end else begin
      scl_q      <= scl_f;
      sda_q      <= sda_f;
      chan_upd_o <= 1'b0;
      test_upd_o <= 1'b0;
      if (start_ev) begin
        state   <= ST_ADDR;
        bitcnt  <= '0;
        drive_o <= 1'b0;
      end else if (stop_ev) begin
        state   <= ST_IDLE;
        drive_o <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_DATA: begin
            if (scl_rise && !byte_full) begin
              shreg  <= {shreg[BYTE_W-2:0], sda_f};
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall && byte_full) begin
              bitcnt <= '0;
              if (state == ST_ADDR) begin
                if (shreg == DEV_ADDR) begin
                  drive_o <= 1'b1;
                  state   <= ST_ADDR_ACK;
                end else begin
                  state <= ST_SKIP;
                end
              end else begin
                drive_o <= 1'b1;
                state   <= ST_DATA_ACK;
                if (shreg[BYTE_W-1]) begin
                  chan_o     <= shreg[CODE_W-1:0];
                  chan_upd_o <= 1'b1;
                end else begin
                  test_o     <= shreg[CODE_W-1:0];
                  test_upd_o <= 1'b1;
                end
              end
            end
          end
          ST_ADDR_ACK, ST_DATA_ACK: begin
            if (scl_fall) begin
              drive_o <= 1'b0;
              state   <= ST_DATA;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/ctl2w_index_decode.sv
module ctl2w_index_decode
  import ctl2w_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [CODE_W-1:0]  code_i,
  output logic [IDX_W-1:0]   index_o,
  output logic [RATIO_W-1:0] ratio_o
);
  logic [IDX_W-1:0] idx_n;
  assign idx_n = code_to_index(code_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      index_o <= code_to_index(CHAN_RESET);
      ratio_o <= RATIO_W'(RATIO_BASE8) + RATIO_W'(code_to_index(CHAN_RESET));
    end else begin
      index_o <= idx_n;
      ratio_o <= RATIO_W'(RATIO_BASE8) + RATIO_W'(idx_n);
    end
  end
endmodule

// File: rtl/ctl2w_slave.sv
module ctl2w_slave
  import ctl2w_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_drive_o,
  output logic [CODE_W-1:0]  chan_code_o,
  output logic [CODE_W-1:0]  test_mode_o,
  output logic [IDX_W-1:0]   synth_index_o,
  output logic [RATIO_W-1:0] ratio_x8_o,
  output logic               chan_upd_o,
  output logic               test_upd_o
);
  logic [1:0] raw_lines, clean_lines;
  assign raw_lines = {sda_i, scl_i};

  genvar k;
  generate
    for (k = 0; k < 2; k++) begin : g_line
      ctl2w_line_filter #(.SYNC_STAGES(2), .VOTE_TAPS(3)) u_filt (
        .clk(clk), .rst(rst), .line_i(raw_lines[k]), .line_o(clean_lines[k])
      );
    end
  endgenerate

  ctl2w_frame_engine u_engine (
    .clk(clk), .rst(rst),
    .scl_f(clean_lines[0]), .sda_f(clean_lines[1]),
    .drive_o(sda_drive_o),
    .chan_o(chan_code_o), .test_o(test_mode_o),
    .chan_upd_o(chan_upd_o), .test_upd_o(test_upd_o)
  );

  ctl2w_index_decode u_decode (
    .clk(clk), .rst(rst), .code_i(chan_code_o),
    .index_o(synth_index_o), .ratio_o(ratio_x8_o)
  );
endmodule

// File: rtl/ctl2w_slave_checker.sv
module ctl2w_slave_checker (
  input logic        clk,
  input logic        rst,
  input logic        sda_drive_o,
  input logic [6:0]  chan_code_o,
  input logic [6:0]  test_mode_o,
  input logic [7:0]  synth_index_o,
  input logic [11:0] ratio_x8_o,
  input logic        chan_upd_o,
  input logic        test_upd_o
);
  a_r7_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(chan_upd_o && test_upd_o));
  a_r7_chan_strobe_pulse: assert property (@(posedge clk) disable iff (rst)
    chan_upd_o |=> !chan_upd_o);
  a_r7_test_strobe_pulse: assert property (@(posedge clk) disable iff (rst)
    test_upd_o |=> !test_upd_o);
  a_r4_chan_only_on_strobe: assert property (@(posedge clk) disable iff (rst)
    !$stable(chan_code_o) |-> chan_upd_o);
  a_r5_test_only_on_strobe: assert property (@(posedge clk) disable iff (rst)
    !$stable(test_mode_o) |-> test_upd_o);
  a_r8_index_follows_chan: assert property (@(posedge clk) disable iff (rst)
    !$stable(synth_index_o) |-> $past(chan_upd_o));
  a_r8_index_in_range: assert property (@(posedge clk) disable iff (rst)
    (synth_index_o >= 8'd6) && (synth_index_o <= 8'd133));
  a_r9_ratio_tracks_index: assert property (@(posedge clk) disable iff (rst)
    ratio_x8_o == 12'd2880 + {4'd0, synth_index_o});
  a_r7_no_strobe_with_drive_low: assert property (@(posedge clk) disable iff (rst)
    (chan_upd_o || test_upd_o) |-> sda_drive_o);
endmodule

bind ctl2w_slave ctl2w_slave_checker u_chk (
  .clk(clk), .rst(rst), .sda_drive_o(sda_drive_o),
  .chan_code_o(chan_code_o), .test_mode_o(test_mode_o),
  .synth_index_o(synth_index_o), .ratio_x8_o(ratio_x8_o),
  .chan_upd_o(chan_upd_o), .test_upd_o(test_upd_o)
);

// File: tb/ctl2w_slave_tb_top.sv
module ctl2w_slave_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int H = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_drive_o, chan_upd_o, test_upd_o;
  logic [6:0]  chan_code_o, test_mode_o;
  logic [7:0]  synth_index_o;
  logic [11:0] ratio_x8_o;
  logic sda_line;

  int checks = 0;
  int errors = 0;
  int chan_strobes = 0;
  int test_strobes = 0;
  bit done = 1'b0;
  logic [6:0] exp_chan = 7'b1000101;
  logic [6:0] exp_test = 7'd0;

  assign sda_line = sda_m & ~sda_drive_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctl2w_slave dut_i (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line),
    .sda_drive_o(sda_drive_o), .chan_code_o(chan_code_o), .test_mode_o(test_mode_o),
    .synth_index_o(synth_index_o), .ratio_x8_o(ratio_x8_o),
    .chan_upd_o(chan_upd_o), .test_upd_o(test_upd_o)
  );

  always @(posedge clk) begin
    if (!rst) begin
      if (chan_upd_o) chan_strobes++;
      if (test_upd_o) test_strobes++;
    end
  end

  function automatic int idx_of(input logic [6:0] code);
    return (int'(code) < 6) ? int'(code) + 128 : int'(code);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; waitc(H/2);
    scl_m = 1'b1; waitc(H);
    sda_m = 1'b0; waitc(H);
    scl_m = 1'b0; waitc(H/2);
  endtask

  task automatic bus_stop();
    scl_m = 1'b0; waitc(H/2);
    sda_m = 1'b0; waitc(H/2);
    scl_m = 1'b1; waitc(H);
    sda_m = 1'b1; waitc(H);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nbits, input int glitch_bit);
    for (int i = 7; i > 7 - nbits; i--) begin
      waitc(H/2);
      sda_m = b[i];
      if (i == glitch_bit) begin
        waitc(2); scl_m = 1'b1; waitc(1); scl_m = 1'b0; waitc(H/2 - 3);
      end else begin
        waitc(H/2);
      end
      scl_m = 1'b1; waitc(H/2);
      if (i == 7) chk("R11 drive released in first bit", int'(sda_drive_o), 0);
      waitc(H/2);
      scl_m = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input int glitch_bit, output bit acked);
    send_bits(b, 8, glitch_bit);
    waitc(H/2); sda_m = 1'b1; waitc(H/2);
    scl_m = 1'b1; waitc(H/2);
    acked = sda_drive_o;
    waitc(H/2);
    scl_m = 1'b0;
  endtask

  task automatic check_regs(input string tag);
    waitc(8);
    chk({tag, " R4 channel"}, int'(chan_code_o), int'(exp_chan));
    chk({tag, " R5 test"}, int'(test_mode_o), int'(exp_test));
    chk({tag, " R8 index"}, int'(synth_index_o), idx_of(exp_chan));
    chk({tag, " R9 ratio"}, int'(ratio_x8_o), 2880 + idx_of(exp_chan));
  endtask

  task automatic one_byte_frame(input logic [7:0] d);
    bit a;
    bus_start();
    send_byte(8'hC0, -1, a); chk("R2 address ack", int'(a), 1);
    send_byte(d, -1, a);     chk("R3 data ack", int'(a), 1);
    bus_stop();
    if (d[7]) exp_chan = d[6:0]; else exp_test = d[6:0];
    check_regs("directed");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit a;
    int cs0, ts0;
    void'($urandom(32'd7321));
    waitc(5);
    rst = 1'b0;
    waitc(4);
    chk("R6 reset channel", int'(chan_code_o), 7'b1000101);
    chk("R6 reset test", int'(test_mode_o), 0);
    chk("R6 reset index", int'(synth_index_o), 69);
    chk("R6 reset ratio", int'(ratio_x8_o), 2949);
    chk("R6 reset drive", int'(sda_drive_o), 0);

    // R8 wrap corners and edges
    one_byte_frame(8'h80);
    one_byte_frame(8'h85);
    one_byte_frame(8'h86);
    one_byte_frame(8'hFF);
    one_byte_frame(8'h2A);

    // R7: two-byte frame gives one strobe of each kind
    cs0 = chan_strobes; ts0 = test_strobes;
    bus_start();
    send_byte(8'hC0, -1, a);
    send_byte(8'hC4, -1, a); chk("R3 chan byte ack", int'(a), 1);
    send_byte(8'h13, -1, a); chk("R3 test byte ack", int'(a), 1);
    bus_stop();
    exp_chan = 7'h44; exp_test = 7'h13;
    check_regs("two-byte");
    chk("R7 chan strobe count", chan_strobes - cs0, 1);
    chk("R7 test strobe count", test_strobes - ts0, 1);

    // R2: wrong address
    bus_start();
    send_byte(8'hC2, -1, a); chk("R2 wrong address nack", int'(a), 0);
    send_byte(8'h91, -1, a); chk("R2 data after nack", int'(a), 0);
    bus_stop();
    check_regs("wrong-addr");

    // R1: byte after stop without start
    send_byte(8'h8F, -1, a); chk("R1 byte without start", int'(a), 0);
    bus_stop();
    check_regs("no-start");

    // R10: start mid byte aborts
    cs0 = chan_strobes;
    bus_start();
    send_byte(8'hC0, -1, a);
    send_bits(8'h9E, 5, -1);
    bus_start();
    send_byte(8'hC0, -1, a); chk("R10 address after restart", int'(a), 1);
    chk("R10 no strobe from aborted byte", chan_strobes - cs0, 0);
    chk("R10 channel kept", int'(chan_code_o), int'(exp_chan));
    send_byte(8'h0B, -1, a);
    bus_stop();
    exp_test = 7'h0B;
    check_regs("abort");

    // R12: single-cycle clock glitch ignored
    bus_start();
    send_byte(8'hC0, 3, a); chk("R12 address with glitch", int'(a), 1);
    send_byte(8'hB3, 2, a);
    bus_stop();
    exp_chan = 7'h33;
    check_regs("glitch");

    // random frames
    for (int f = 0; f < 40; f++) begin
      logic [7:0] addr, d;
      int n;
      bit ok;
      addr = ($urandom % 5 == 0) ? 8'(($urandom % 255) + 1) ^ 8'hC0 : 8'hC0;
      ok = (addr == 8'hC0);
      n = 1 + int'($urandom % 3);
      cs0 = chan_strobes; ts0 = test_strobes;
      bus_start();
      send_byte(addr, -1, a); chk("R2 random address", int'(a), int'(ok));
      for (int b = 0; b < n; b++) begin
        d = 8'($urandom);
        send_byte(d, -1, a); chk("R3 random data ack", int'(a), int'(ok));
        if (ok) begin
          if (d[7]) exp_chan = d[6:0]; else exp_test = d[6:0];
        end
      end
      bus_stop();
      check_regs("random");
      chk("R7 random strobe total", (chan_strobes - cs0) + (test_strobes - ts0), ok ? n : 0);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule